// File: doc/BRIEF.md
# LDPC Accelerated Schedule Sequencer

This block is the control core of a message-passing decoder for a rate-1/2, (3,6)-regular LDPC code. Every bit node joins three checks, and every check covers six bits. The sequencer does no arithmetic. It tells an array of check-update and bit-update units what to do next and when to do it.

The parity rows are split into four row groups that always run in ascending order. Column updates do not wait for all rows to finish. After the second row group, each row group is followed by three column sub-steps, so bit updates always consume check messages produced in the same iteration. One iteration is therefore thirteen steps, in this order:

- row group 0
- row group 1
- column group 0, sub-steps 0 to 2
- row group 2
- column group 1, sub-steps 0 to 2
- row group 3
- column group 2, sub-steps 0 to 2

That gives nine column steps per iteration, against three when all rows run before all columns.

Each step is launched with a one-cycle pulse. The sequencer then waits for a step-done handshake from the units. It counts completed iterations and stops in one of two cases:

- the iteration cap is reached, or
- a parity-pass flag is presented together with the last step's done.

It then reports the iteration count and whether the decode converged.

Top module: `ldpc_sched_seq`

## Requirements
- R1: While reset is asserted and after it, until a start is accepted, busy_o, done_o, converged_o, both go pulses, all enables and bank_sel_o are 0, and iter_cnt_o is 0.
- R2: A start_i seen high at a clock edge while idle or finished produces, in the next cycle, a row_go_o pulse for row group 0. Every step is launched by exactly one one-cycle pulse: row_go_o for row steps and col_go_o for column steps, never both.
- R3: The steps of each iteration follow the fixed 13-step order. During a row step, row_grp_o carries the group (0 to 3) and col_grp_o and col_sub_o are 0. During a column step, col_grp_o (0 to 2) and col_sub_o (0 to 2) are set and row_grp_o is 0.
- R4: After a launch, the sequencer waits for step_done_i and ignores it during the launch cycle. When step_done_i is sampled during the wait, the next step's pulse appears in the following cycle, unless decoding ends there.
- R5: For the whole of a row step, all 24 check-unit enables (chk_en_o) are 1 and all 48 bit-unit enables are 0. For the whole of a column step, all 48 bit-unit enables (bit_en_o) are 1 and all check enables are 0.
- R6: During a column step, bank_sel_o equals 6*col_grp + 2*col_sub, which addresses the first of a pair among 18 banks. During a row step it is 0.
- R7: iter_cnt_o increases by one when the done of the thirteenth step is sampled, and at no other time.
- R8: With no parity pass, decoding ends after 10 iterations. done_o rises, iter_cnt_o is 10, converged_o is 0, and exactly 130 steps have been launched.
- R9: parity_ok_i high in the same cycle as the thirteenth step's done ends decoding after that iteration, with converged_o 1 and iter_cnt_o equal to the iterations run. This includes iteration 10, where the cap and the pass coincide.
- R10: parity_ok_i at any other time has no effect on the step sequence or on the stop.
- R11: start_i while busy_o is high has no effect. The run continues and its step count and iteration count are unchanged.
- R12: done_o, iter_cnt_o and converged_o hold until the next accepted start. That start clears done_o, converged_o and iter_cnt_o in the cycle its first pulse appears.
- R13: Asserting rst_n in the middle of a run returns the sequencer at once to idle with iter_cnt_o at 0, and a later start runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| start_i | input | 1 | Request to begin decoding |
| step_done_i | input | 1 | Units report the current step complete |
| parity_ok_i | input | 1 | Parity check passed; sampled with the last step's done |
| row_go_o | output | 1 | One-cycle launch of a row step |
| col_go_o | output | 1 | One-cycle launch of a column step |
| row_grp_o | output | 2 | Row group of the current row step |
| col_grp_o | output | 2 | Column group of the current column step |
| col_sub_o | output | 2 | Sub-step of the current column step |
| chk_en_o | output | 24 | Check-unit enables, 8 lanes by 3 units |
| bit_en_o | output | 48 | Bit-unit enables, 8 lanes by 6 units |
| bank_sel_o | output | 5 | Message bank select for column steps |
| busy_o | output | 1 | Decoding in progress |
| done_o | output | 1 | Decoding finished; results valid |
| converged_o | output | 1 | Finished because of a parity pass |
| iter_cnt_o | output | 4 | Completed iterations |

## Verification
Two pairs of events can fall in the same cycle. The parity-pass stop and the iteration-cap stop can coincide at the end of iteration 10. A start request can also arrive while a step is being waited on. The bench's unit stub raises parity_ok_i together with the thirteenth done of iteration 10 and expects converged_o = 1, iter_cnt_o = 10 and exactly 130 launches. In another run it repeatedly pulses start_i mid-decode and expects the step count of an undisturbed run. A third run holds parity_ok_i high everywhere except at iteration ends, to show that only the end-of-iteration sample counts.

// File: rtl/ldpc_seq_pkg.sv
package ldpc_seq_pkg;

  localparam int ROW_GRPS  = 4;
  localparam int LEAD_ROWS = 2;
  localparam int COL_SUBS  = 3;
  localparam int COL_GRPS  = ROW_GRPS - 1;
  localparam int STEPS     = ROW_GRPS + COL_GRPS * COL_SUBS;
  localparam int STEP_W    = $clog2(STEPS);
  localparam int GRP_W     = 2;
  localparam int BLOCK     = COL_SUBS + 1;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_FIN   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic             is_col;
    logic [GRP_W-1:0] row_grp;
    logic [GRP_W-1:0] col_grp;
    logic [GRP_W-1:0] col_sub;
  } step_info_t;

  // Two leading row steps, then blocks of (COL_SUBS column sub-steps + one row step).
  function automatic step_info_t decode_step(input logic [STEP_W-1:0] idx);
    step_info_t s;
    int j;
    s = '0;
    if (int'(idx) < LEAD_ROWS) begin
      s.row_grp = GRP_W'(idx);
    end else begin
      j = int'(idx) - LEAD_ROWS;
      if ((j % BLOCK) == COL_SUBS) begin
        s.row_grp = GRP_W'(j / BLOCK + LEAD_ROWS);
      end else begin
        s.is_col  = 1'b1;
        s.col_grp = GRP_W'(j / BLOCK);
        s.col_sub = GRP_W'(j % BLOCK);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl #(
  parameter int MAX_ITER = 10,
  parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ITER_W-1:0] cnt_o,
  output logic              at_last_o
);

  logic [ITER_W-1:0] cnt_q;
  logic [ITER_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign at_last_o = (cnt_q == ITER_W'(MAX_ITER - 1));

endmodule

// File: rtl/ldpc_unit_drive.sv
module ldpc_unit_drive
  import ldpc_seq_pkg::*;
#(
  parameter int LANES        = 8,
  parameter int CHK_PER_LANE = 3,
  parameter int BIT_PER_LANE = 6,
  parameter int BETA_BANKS   = 18,
  parameter int CHK_W        = LANES * CHK_PER_LANE,
  parameter int BIT_W        = LANES * BIT_PER_LANE,
  parameter int BANK_W       = $clog2(BETA_BANKS)
) (
  input  logic              active_i,
  input  step_info_t        info_i,
  output logic [CHK_W-1:0]  chk_en_o,
  output logic [BIT_W-1:0]  bit_en_o,
  output logic [BANK_W-1:0] bank_sel_o
);

  localparam int BANKS_PER_GRP = BETA_BANKS / COL_GRPS;
  localparam int BANKS_PER_SUB = BANKS_PER_GRP / COL_SUBS;

  logic row_on;
  logic col_on;

  assign row_on = active_i & ~info_i.is_col;
  assign col_on = active_i &  info_i.is_col;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign chk_en_o[ln*CHK_PER_LANE +: CHK_PER_LANE] = {CHK_PER_LANE{row_on}};
    assign bit_en_o[ln*BIT_PER_LANE +: BIT_PER_LANE] = {BIT_PER_LANE{col_on}};
  end

  always_comb begin
    bank_sel_o = '0;
    if (col_on)
      bank_sel_o = BANK_W'(BANKS_PER_GRP * int'(info_i.col_grp)
                         + BANKS_PER_SUB * int'(info_i.col_sub));
  end

endmodule

// File: rtl/ldpc_sched_seq.sv
module ldpc_sched_seq
  import ldpc_seq_pkg::*;
#(
  parameter int LANES        = 8,
  parameter int CHK_PER_LANE = 3,
  parameter int BIT_PER_LANE = 6,
  parameter int BETA_BANKS   = 18,
  parameter int MAX_ITER     = 10,
  parameter int CHK_W        = LANES * CHK_PER_LANE,
  parameter int BIT_W        = LANES * BIT_PER_LANE,
  parameter int BANK_W       = $clog2(BETA_BANKS),
  parameter int ITER_W       = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_done_i,
  input  logic              parity_ok_i,
  output logic              row_go_o,
  output logic              col_go_o,
  output logic [1:0]        row_grp_o,
  output logic [1:0]        col_grp_o,
  output logic [1:0]        col_sub_o,
  output logic [CHK_W-1:0]  chk_en_o,
  output logic [BIT_W-1:0]  bit_en_o,
  output logic [BANK_W-1:0] bank_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              converged_o,
  output logic [ITER_W-1:0] iter_cnt_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_m1_q, rst_m2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1_q <= 1'b0;
      rst_m2_q <= 1'b0;
    end else begin
      rst_m1_q <= 1'b1;
      rst_m2_q <= rst_m1_q;
    end
  end
  assign rst_int_n = rst_m2_q;

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              conv_q, conv_d;
  logic              iter_clr, iter_inc, at_last;
  logic              active;
  step_info_t        info;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    conv_d   = conv_q;
    iter_clr = 1'b0;
    iter_inc = 1'b0;
    unique case (state_q)
      SQ_IDLE, SQ_FIN: begin
        if (start_i) begin
          state_d  = SQ_ISSUE;
          step_d   = '0;
          conv_d   = 1'b0;
          iter_clr = 1'b1;
        end
      end
      SQ_ISSUE: state_d = SQ_WAIT;
      SQ_WAIT: begin
        if (step_done_i) begin
          if (step_q == LAST_STEP) begin
            iter_inc = 1'b1;
            if (parity_ok_i || at_last) begin
              state_d = SQ_FIN;
              conv_d  = parity_ok_i;
            end else begin
              state_d = SQ_ISSUE;
              step_d  = '0;
            end
          end else begin
            state_d = SQ_ISSUE;
            step_d  = step_q + 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      conv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      conv_q  <= conv_d;
    end
  end

  ldpc_iter_ctrl #(
    .MAX_ITER (MAX_ITER),
    .ITER_W   (ITER_W)
  ) u_iter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (iter_clr),
    .inc_i     (iter_inc),
    .cnt_o     (iter_cnt_o),
    .at_last_o (at_last)
  );

  assign info   = decode_step(step_q);
  assign active = (state_q == SQ_ISSUE) || (state_q == SQ_WAIT);

  ldpc_unit_drive #(
    .LANES        (LANES),
    .CHK_PER_LANE (CHK_PER_LANE),
    .BIT_PER_LANE (BIT_PER_LANE),
    .BETA_BANKS   (BETA_BANKS),
    .CHK_W        (CHK_W),
    .BIT_W        (BIT_W),
    .BANK_W       (BANK_W)
  ) u_drive (
    .active_i   (active),
    .info_i     (info),
    .chk_en_o   (chk_en_o),
    .bit_en_o   (bit_en_o),
    .bank_sel_o (bank_sel_o)
  );

  assign row_go_o    = (state_q == SQ_ISSUE) && !info.is_col;
  assign col_go_o    = (state_q == SQ_ISSUE) &&  info.is_col;
  assign row_grp_o   = active ? info.row_grp : '0;
  assign col_grp_o   = active ? info.col_grp : '0;
  assign col_sub_o   = active ? info.col_sub : '0;
  assign busy_o      = active;
  assign done_o      = (state_q == SQ_FIN);
  assign converged_o = conv_q;

endmodule

// File: rtl/ldpc_sched_seq_chk.sv
module ldpc_sched_seq_chk #(
  parameter int CHK_W      = 24,
  parameter int BIT_W      = 48,
  parameter int BANK_W     = 5,
  parameter int ITER_W     = 4,
  parameter int BETA_BANKS = 18,
  parameter int MAX_ITER   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              step_done_i,
  input logic              row_go_o,
  input logic              col_go_o,
  input logic [CHK_W-1:0]  chk_en_o,
  input logic [BIT_W-1:0]  bit_en_o,
  input logic [BANK_W-1:0] bank_sel_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              converged_o,
  input logic [ITER_W-1:0] iter_cnt_o
);

  assert_go_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_go_o, col_go_o}));

  assert_go_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (row_go_o || col_go_o) |=> !(row_go_o || col_go_o));

  assert_en_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((|chk_en_o) && (|bit_en_o)));

  assert_bank_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel_o < BANK_W'(BETA_BANKS));

  assert_iter_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (iter_cnt_o == $past(iter_cnt_o)) ||
               (iter_cnt_o == ITER_W'($past(iter_cnt_o) + 1'b1)));

  assert_iter_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt_o <= ITER_W'(MAX_ITER));

  assert_conv_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    converged_o |-> done_o);

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !step_done_i) |=> busy_o);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

bind ldpc_sched_seq ldpc_sched_seq_chk #(
  .CHK_W      (CHK_W),
  .BIT_W      (BIT_W),
  .BANK_W     (BANK_W),
  .ITER_W     (ITER_W),
  .BETA_BANKS (BETA_BANKS),
  .MAX_ITER   (MAX_ITER)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .step_done_i (step_done_i),
  .row_go_o    (row_go_o),
  .col_go_o    (col_go_o),
  .chk_en_o    (chk_en_o),
  .bit_en_o    (bit_en_o),
  .bank_sel_o  (bank_sel_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .converged_o (converged_o),
  .iter_cnt_o  (iter_cnt_o)
);

// File: tb/ldpc_sched_seq_bench.sv
module ldpc_sched_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NSTEP      = 13;

  // {is_col, row_grp, col_grp, col_sub, bank}
  localparam logic [11:0] EXP_STEP [NSTEP] = '{
    {1'b0, 2'd0, 2'd0, 2'd0, 5'd0},
    {1'b0, 2'd1, 2'd0, 2'd0, 5'd0},
    {1'b1, 2'd0, 2'd0, 2'd0, 5'd0},
    {1'b1, 2'd0, 2'd0, 2'd1, 5'd2},
    {1'b1, 2'd0, 2'd0, 2'd2, 5'd4},
    {1'b0, 2'd2, 2'd0, 2'd0, 5'd0},
    {1'b1, 2'd0, 2'd1, 2'd0, 5'd6},
    {1'b1, 2'd0, 2'd1, 2'd1, 5'd8},
    {1'b1, 2'd0, 2'd1, 2'd2, 5'd10},
    {1'b0, 2'd3, 2'd0, 2'd0, 5'd0},
    {1'b1, 2'd0, 2'd2, 2'd0, 5'd12},
    {1'b1, 2'd0, 2'd2, 2'd1, 5'd14},
    {1'b1, 2'd0, 2'd2, 2'd2, 5'd16}
  };

  logic        clk, rst_n, start_i, step_done_i, parity_ok_i;
  logic        row_go_o, col_go_o, busy_o, done_o, converged_o;
  logic [1:0]  row_grp_o, col_grp_o, col_sub_o;
  logic [23:0] chk_en_o;
  logic [47:0] bit_en_o;
  logic [4:0]  bank_sel_o;
  logic [3:0]  iter_cnt_o;

  ldpc_sched_seq u_ldpc_sched_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_done_i(step_done_i),
    .parity_ok_i(parity_ok_i), .row_go_o(row_go_o), .col_go_o(col_go_o),
    .row_grp_o(row_grp_o), .col_grp_o(col_grp_o), .col_sub_o(col_sub_o),
    .chk_en_o(chk_en_o), .bit_en_o(bit_en_o), .bank_sel_o(bank_sel_o),
    .busy_o(busy_o), .done_o(done_o), .converged_o(converged_o),
    .iter_cnt_o(iter_cnt_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int run_go = 0, gap_err = 0, pass_at = 0, cnt = 0, cur_step = 0, cur_it = 0;
  bit glitch = 0, pend = 0, exp_go = 0, prev_busy = 0, fin, par;
  logic [11:0] log_vec [NSTEP];
  bit          log_en  [NSTEP];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // unit stub: answers each launch with step_done after 1..3 cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; exp_go = 0;
      step_done_i = 1'b0; parity_ok_i = 1'b0;
    end else begin
      if (exp_go && !(row_go_o || col_go_o)) gap_err++;
      exp_go = 0;
      step_done_i = 1'b0;
      parity_ok_i = glitch;
      if (row_go_o || col_go_o) begin
        if (pend) gap_err++;
        if (!prev_busy) run_go = 0;
        cur_step = run_go % NSTEP;
        cur_it   = run_go / NSTEP + 1;
        if (run_go < NSTEP) begin
          log_vec[run_go] = {col_go_o, row_grp_o, col_grp_o, col_sub_o, bank_sel_o};
          log_en[run_go]  = col_go_o ? ((&bit_en_o) && !(|chk_en_o))
                                     : ((&chk_en_o) && !(|bit_en_o));
        end
        run_go++;
        pend = 1;
        cnt  = 1 + (run_go % 3);
      end else if (pend) begin
        cnt--;
        if (cnt == 0) begin
          pend = 0;
          step_done_i = 1'b1;
          fin = (cur_step == NSTEP - 1);
          par = glitch ? !fin : (fin && cur_it == pass_at);
          parity_ok_i = par;
          exp_go = !(fin && (par || cur_it == 10));
        end
      end
      prev_busy = busy_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done(input bit poke);
    int k;
    k = 0;
    while (!done_o && k < 5000) begin
      @(negedge clk);
      k++;
      if (poke && busy_o && (k % 7) == 0) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input int pa, input bit gl, input int e_it, input bit e_cv,
                     input bit poke, input string req);
    pass_at = pa; glitch = gl; gap_err = 0;
    pulse_start();
    check(busy_o && row_go_o && !done_o && iter_cnt_o == 0, "R2/R12 start", iter_cnt_o, 0);
    wait_done(poke);
    check(done_o == 1'b1, {req, " done"}, done_o, 1);
    check(iter_cnt_o == e_it, {req, " iterations"}, iter_cnt_o, e_it);
    check(converged_o == e_cv, {req, " converged"}, converged_o, e_cv);
    check(run_go == NSTEP * e_it, {req, " R7 launches"}, run_go, NSTEP * e_it);
    check(gap_err == 0, "R4 launch timing", gap_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !converged_o && iter_cnt_o == 0 && !row_go_o && !col_go_o
          && chk_en_o == 0 && bit_en_o == 0 && bank_sel_o == 0, "R1 in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !row_go_o && !col_go_o && iter_cnt_o == 0, "R1 after release", busy_o, 0);

    // R8: no parity pass, runs to the cap
    run(0, 0, 10, 0, 0, "R8");
    for (int i = 0; i < NSTEP; i++) begin
      check(log_vec[i] == EXP_STEP[i], $sformatf("R3/R6 step %0d", i),
            int'(log_vec[i]), int'(EXP_STEP[i]));
      check(log_en[i], $sformatf("R5 enables step %0d", i), log_en[i], 1);
    end
    repeat (5) @(negedge clk);
    check(done_o && iter_cnt_o == 10 && !converged_o, "R12 hold", iter_cnt_o, 10);

    // R9: pass at iteration 3
    run(3, 0, 3, 1, 0, "R9");
    // R10: parity high everywhere except at iteration ends
    run(0, 1, 10, 0, 0, "R10");
    // R9: pass coincides with the cap
    run(10, 0, 10, 1, 0, "R9 collision");
    // R11: start pulses while busy
    run(2, 0, 2, 1, 1, "R11");

    // R13: reset in mid-run
    pass_at = 0; glitch = 0;
    pulse_start();
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && iter_cnt_o == 0 && !row_go_o && !col_go_o,
          "R13 reset mid-run", iter_cnt_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(1, 0, 1, 1, 0, "R13 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule